// File: doc/BRIEF.md
# Serial Port Interrupt Request and Status Logic

This block produces the interrupt request of a small serial communications port. Two conditions from the port's datapaths can call for the CPU's attention. One is a received byte waiting in the holding register. The other is a transmit buffer that has drained. Each condition is kept as a sticky flag and has its own enable bit in a command register. A summary bit in the status register reports whether any enabled condition is pending.

The request output is an active-low drive enable. When it is 0 the pad pulls a shared interrupt line low, and when it is 1 the pad lets go of the line. Several ports can share one line, and a pull-up returns the line high once none of them drives it. The request is a level. It remains active until software services every enabled cause. Software acknowledges a received byte by reading the data register, and a drained transmitter by writing the data register.

The CPU side is a four-location register port with chip select, read and write strobes, a two-bit register select and a byte-wide data bus. Read data is registered and appears in the cycle after the read strobe.

Top module: `serial_irq_status`

## Requirements
- R1: After reset, `irq_n` is 1, `rdata` is 0, the status register reads 0x10 (transmit empty, nothing else), the command register reads 0x00 and the data register reads 0x00. `rdata` is 0 in every cycle that does not follow a selected read.
- R2: A pulse on `rx_load` stores `rx_byte` in the holding register and sets status bit 3 (receive full). A flag holds its value while no event and no acknowledge reaches it.
- R3: A selected read of register 0 (data) returns the held byte in the next cycle and clears status bit 3. A read of any other register, or a read without `cs`, leaves bit 3 unchanged.
- R4: A pulse on `tx_done` sets status bit 4 (transmit empty). A selected write to register 0 clears it.
- R5: Register 2 (command) is read/write. Bit 0 enables the receive interrupt and bit 1 enables the transmit interrupt, and the other bits read 0. Writes to register 1 (status) are ignored. Register 3 reads 0.
- R6: Status bit 7 equals (bit 3 AND receive enable) OR (bit 4 AND transmit enable). It clears by itself only when no enabled source is left.
- R7: `irq_n` is 0 exactly when status bit 7 is 1. It changes on the same clock edge as the flag or enable that causes the change, and it stays low while the cause stays.
- R8: A source whose enable bit is 0 never sets bit 7 and never drives `irq_n` low, even while its flag is set.
- R9: When an event and the acknowledge of the same source fall in one cycle, the event wins and the flag stays set. A status read in the cycle of an event returns the value from before the event, and the event is not lost.
- R10: Several instances can share one wired-AND line. The line is low while any instance has `irq_n` at 0, and it is high once all instances have released it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Chip select for the register port |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| addr | input | 2 | Register select: 0 data, 1 status, 2 command, 3 unused |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data, valid the cycle after `rd` |
| rx_load | input | 1 | Receiver event pulse: a byte has arrived |
| rx_byte | input | 8 | Received byte, captured on `rx_load` |
| tx_done | input | 1 | Transmitter event pulse: buffer became empty |
| irq_n | output | 1 | Active-low drive enable for the shared interrupt line |

## Verification
Two functions of the block can fall in the same cycle. One is the datapath setting a flag. The other is the CPU either acknowledging that same flag or taking a snapshot of the status register. The bench provokes this by raising `rx_load` in the same cycle as a data-register read, `tx_done` in the same cycle as a data-register write, and `rx_load` in the same cycle as a status read. It judges the outcome in two steps. First, the data or status returned in that cycle must show the state before the event. Second, a later status read must still show the flag, and `irq_n` must still be low.

// File: rtl/serial_irq_pkg.sv
package serial_irq_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_DATA = 2'd0,
    REG_STAT = 2'd1,
    REG_CMD  = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;

  // source indices; the command register enable bit of source i is bit i
  localparam int NSRC   = 2;
  localparam int SRC_RX = 0;
  localparam int SRC_TX = 1;

  // status bit positions, decoded by the interrupt service software
  localparam int STAT_ANY_BIT = 7;
  localparam int STAT_TX_BIT  = 4;
  localparam int STAT_RX_BIT  = 3;
endpackage

// File: rtl/serial_irq_flag.sv
module serial_irq_flag #(
  parameter logic RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic ack_i,
  output logic flag_q,
  output logic flag_d
);
  // an event beats an acknowledge in the same cycle
  always_comb flag_d = set_i ? 1'b1 : (ack_i ? 1'b0 : flag_q);

  always_ff @(posedge clk) begin
    if (rst) flag_q <= RESET_VAL;
    else     flag_q <= flag_d;
  end

  p_set_wins_r9: assert property (@(posedge clk) disable iff (rst)
    set_i |=> flag_q);

  // covers the receive acknowledge (R3) and the transmit acknowledge (R4)
  p_ack_clears_r3: assert property (@(posedge clk) disable iff (rst)
    (ack_i && !set_i) |=> !flag_q);

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!set_i && !ack_i) |=> $stable(flag_q));
endmodule

// File: rtl/serial_irq_regs.sv
module serial_irq_regs
  import serial_irq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs,
  input  logic              rd,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [NSRC-1:0]   ack,
  output logic [NSRC-1:0]   en_q,
  output logic [NSRC-1:0]   en_d
);
  reg_sel_e sel;
  logic     wr_cmd;

  always_comb begin
    sel          = reg_sel_e'(addr);
    wr_cmd       = cs && wr && (sel == REG_CMD);
    ack          = '0;
    ack[SRC_RX]  = cs && rd && (sel == REG_DATA);
    ack[SRC_TX]  = cs && wr && (sel == REG_DATA);
    en_d         = wr_cmd ? wdata[NSRC-1:0] : en_q;
  end

  always_ff @(posedge clk) begin
    if (rst) en_q <= '0;
    else     en_q <= en_d;
  end

  p_cmd_load_r5: assert property (@(posedge clk) disable iff (rst)
    (cs && wr && addr == REG_CMD) |=> (en_q == $past(wdata[NSRC-1:0])));

  p_cmd_keep_r5: assert property (@(posedge clk) disable iff (rst)
    !(cs && wr && addr == REG_CMD) |=> $stable(en_q));
endmodule

// File: rtl/serial_irq_status.sv
module serial_irq_status
  import serial_irq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs,
  input  logic              rd,
  input  logic              wr,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              rx_load,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic              tx_done,
  output logic              irq_n
);
  logic [NSRC-1:0]   ack, en_q, en_d, set, flag_q, flag_d;
  logic [DATA_W-1:0] rx_hold, status;
  logic              any_q, any_d;

  serial_irq_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .cs(cs), .rd(rd), .wr(wr), .addr(addr),
    .wdata(wdata), .ack(ack), .en_q(en_q), .en_d(en_d)
  );

  always_comb begin
    set         = '0;
    set[SRC_RX] = rx_load;
    set[SRC_TX] = tx_done;
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    serial_irq_flag #(.RESET_VAL(i == SRC_TX)) u_flag (
      .clk(clk), .rst(rst), .set_i(set[i]), .ack_i(ack[i]),
      .flag_q(flag_q[i]), .flag_d(flag_d[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst)          rx_hold <= '0;
    else if (rx_load) rx_hold <= rx_byte;
  end

  always_comb begin
    any_q                = |(flag_q & en_q);
    any_d                = |(flag_d & en_d);
    status               = '0;
    status[STAT_ANY_BIT] = any_q;
    status[STAT_TX_BIT]  = flag_q[SRC_TX];
    status[STAT_RX_BIT]  = flag_q[SRC_RX];
  end

  // registered request tracks the next flag state, so it moves on the same edge
  always_ff @(posedge clk) begin
    if (rst) irq_n <= 1'b1;
    else     irq_n <= ~any_d;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (cs && rd) begin
      case (reg_sel_e'(addr))
        REG_DATA: rdata <= rx_hold;
        REG_STAT: rdata <= status;
        REG_CMD:  rdata <= {{(DATA_W-NSRC){1'b0}}, en_q};
        default:  rdata <= '0;
      endcase
    end else rdata <= '0;
  end

  p_irq_level_r7: assert property (@(posedge clk) disable iff (rst)
    irq_n == !(|(flag_q & en_q)));

  p_disabled_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    (en_q == '0) |-> irq_n);

  p_rdata_idle_r1: assert property (@(posedge clk) disable iff (rst)
    !$past(cs && rd) |-> (rdata == '0));
endmodule

// File: tb/test_serial_irq_status.sv
`timescale 1ns/1ps
module test_serial_irq_status;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst, cs, rd, wr, rx_load, tx_done, irq_n;
  logic [1:0] addr;
  logic [7:0] wdata, rdata, rx_byte;
  logic       p_cs, p_rd, p_wr, p_irq_n;
  logic [1:0] p_addr;
  logic [7:0] p_wdata, p_rdata;
  logic       line;

  serial_irq_status i_serial_irq_status (
    .clk(clk), .rst(rst), .cs(cs), .rd(rd), .wr(wr), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rx_load(rx_load), .rx_byte(rx_byte),
    .tx_done(tx_done), .irq_n(irq_n)
  );

  serial_irq_status i_serial_irq_status_peer (
    .clk(clk), .rst(rst), .cs(p_cs), .rd(p_rd), .wr(p_wr), .addr(p_addr),
    .wdata(p_wdata), .rdata(p_rdata), .rx_load(1'b0), .rx_byte(8'h00),
    .tx_done(1'b0), .irq_n(p_irq_n)
  );

  // wired-AND of the shared interrupt line with pull-up (R10)
  assign line = irq_n & p_irq_n;

  int  checks = 0, errors = 0;
  bit  finished = 0;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic       cs, rd, wr;
    logic [1:0] addr;
    logic [7:0] wd;
    logic       rxl;
    logic [7:0] rxb;
    logic       txd;
    logic [7:0] exp_rd;
    logic       exp_irqn;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 30;
  // cs rd wr addr wdata rx_load rx_byte tx_done | rdata irq_n req
  localparam vec_t VECS [NV] = '{
    '{1'b1,1'b1,1'b0,2'd1,8'h00,1'b0,8'h00,1'b0, 8'h10,1'b1,4'd1},  // R1 status after reset
    '{1'b0,1'b0,1'b0,2'd0,8'h00,1'b1,8'hA5,1'b0, 8'h00,1'b1,4'd8},  // R8 rx event while disabled
    '{1'b1,1'b1,1'b0,2'd1,8'h00,1'b0,8'h00,1'b0, 8'h18,1'b1,4'd2},  // R2 receive full set
    '{1'b1,1'b0,1'b1,2'd2,8'h01,1'b0,8'h00,1'b0, 8'h00,1'b0,4'd5},  // R5 enable rx
    '{1'b1,1'b1,1'b0,2'd2,8'h00,1'b0,8'h00,1'b0, 8'h01,1'b0,4'd5},  // R5 read command back
    '{1'b1,1'b1,1'b0,2'd1,8'h00,1'b0,8'h00,1'b0, 8'h98,1'b0,4'd6},  // R6 summary set
    '{1'b0,1'b0,1'b0,2'd0,8'h00,1'b0,8'h00,1'b0, 8'h00,1'b0,4'd7},  // R7 level holds
    '{1'b1,1'b1,1'b0,2'd0,8'h00,1'b0,8'h00,1'b0, 8'hA5,1'b1,4'd3},  // R3 data read acks
    '{1'b1,1'b1,1'b0,2'd1,8'h00,1'b0,8'h00,1'b0, 8'h10,1'b1,4'd3},  // R3 bit 3 cleared
    '{1'b1,1'b0,1'b1,2'd2,8'h03,1'b0,8'h00,1'b0, 8'h00,1'b0,4'd6},  // R6 tx empty enabled
    '{1'b1,1'b0,1'b1,2'd0,8'h55,1'b0,8'h00,1'b0, 8'h00,1'b1,4'd4},  // R4 data write acks tx
    '{1'b1,1'b1,1'b0,2'd1,8'h00,1'b0,8'h00,1'b0, 8'h00,1'b1,4'd4},  // R4 bit 4 cleared
    '{1'b0,1'b0,1'b0,2'd0,8'h00,1'b0,8'h00,1'b1, 8'h00,1'b0,4'd4},  // R4 tx_done sets
    '{1'b1,1'b1,1'b0,2'd1,8'h00,1'b1,8'h3C,1'b0, 8'h90,1'b0,4'd9},  // R9 event during status read
    '{1'b1,1'b1,1'b0,2'd1,8'h00,1'b0,8'h00,1'b0, 8'h98,1'b0,4'd9},  // R9 event kept
    '{1'b1,1'b0,1'b1,2'd0,8'h00,1'b0,8'h00,1'b0, 8'h00,1'b0,4'd6},  // R6 one source left
    '{1'b1,1'b1,1'b0,2'd1,8'h00,1'b0,8'h00,1'b0, 8'h88,1'b0,4'd6},  // R6 summary still set
    '{1'b1,1'b1,1'b0,2'd0,8'h00,1'b1,8'h77,1'b0, 8'h3C,1'b0,4'd9},  // R9 rx event beats read ack
    '{1'b1,1'b1,1'b0,2'd1,8'h00,1'b0,8'h00,1'b0, 8'h88,1'b0,4'd9},  // R9 flag stays
    '{1'b1,1'b1,1'b0,2'd0,8'h00,1'b0,8'h00,1'b0, 8'h77,1'b1,4'd3},  // R3 new byte, released
    '{1'b1,1'b0,1'b1,2'd0,8'h00,1'b0,8'h00,1'b1, 8'h00,1'b0,4'd9},  // R9 tx event beats write ack
    '{1'b1,1'b1,1'b0,2'd1,8'h00,1'b0,8'h00,1'b0, 8'h90,1'b0,4'd9},  // R9 tx flag stays
    '{1'b1,1'b0,1'b1,2'd1,8'hFF,1'b0,8'h00,1'b0, 8'h00,1'b0,4'd5},  // R5 status write ignored
    '{1'b1,1'b1,1'b0,2'd1,8'h00,1'b0,8'h00,1'b0, 8'h90,1'b0,4'd5},  // R5 status unchanged
    '{1'b1,1'b0,1'b1,2'd2,8'h00,1'b0,8'h00,1'b0, 8'h00,1'b1,4'd8},  // R8 disable with flag set
    '{1'b1,1'b1,1'b0,2'd1,8'h00,1'b0,8'h00,1'b0, 8'h10,1'b1,4'd8},  // R8 no summary
    '{1'b1,1'b1,1'b0,2'd3,8'h00,1'b0,8'h00,1'b0, 8'h00,1'b1,4'd5},  // R5 unused register
    '{1'b0,1'b0,1'b0,2'd0,8'h00,1'b1,8'h11,1'b0, 8'h00,1'b1,4'd2},  // R2 second byte
    '{1'b0,1'b1,1'b0,2'd0,8'h00,1'b0,8'h00,1'b0, 8'h00,1'b1,4'd3},  // R3 read without cs
    '{1'b1,1'b1,1'b0,2'd1,8'h00,1'b0,8'h00,1'b0, 8'h18,1'b1,4'd3}   // R3 flag kept
  };

  task automatic idle_all();
    cs = 0; rd = 0; wr = 0; addr = 0; wdata = 0; rx_load = 0; rx_byte = 0; tx_done = 0;
    p_cs = 0; p_rd = 0; p_wr = 0; p_addr = 0; p_wdata = 0;
  endtask

  task automatic dut_access(logic r, logic [1:0] a, logic [7:0] d);
    cs = 1; rd = r; wr = !r; addr = a; wdata = d;
    @(negedge clk);
    idle_all();
  endtask

  task automatic peer_write(logic [1:0] a, logic [7:0] d);
    p_cs = 1; p_wr = 1; p_addr = a; p_wdata = d;
    @(negedge clk);
    idle_all();
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog (all): actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    idle_all();
    rst = 1;
    repeat (3) @(negedge clk);
    chk("R1 irq_n in reset", irq_n, 1);
    chk("R1 rdata in reset", rdata, 0);
    rst = 0;

    for (int i = 0; i < NV; i++) begin
      cs = VECS[i].cs; rd = VECS[i].rd; wr = VECS[i].wr; addr = VECS[i].addr;
      wdata = VECS[i].wd; rx_load = VECS[i].rxl; rx_byte = VECS[i].rxb;
      tx_done = VECS[i].txd;
      @(negedge clk);
      idle_all();
      chk($sformatf("R%0d vec %0d rdata", VECS[i].req, i), rdata, VECS[i].exp_rd);
      chk($sformatf("R%0d vec %0d irq_n", VECS[i].req, i), irq_n, VECS[i].exp_irqn);
    end

    // R1: reset while a byte is pending and sources are enabled
    dut_access(0, 2'd2, 8'h03);
    chk("R1 irq before reset", irq_n, 0);
    rst = 1;
    @(negedge clk);
    rst = 0;
    chk("R1 irq_n after reset", irq_n, 1);
    dut_access(1, 2'd1, 8'h00);
    chk("R1 status after reset", rdata, 8'h10);
    dut_access(1, 2'd2, 8'h00);
    chk("R1 command after reset", rdata, 8'h00);
    dut_access(1, 2'd0, 8'h00);
    chk("R1 data after reset", rdata, 8'h00);
    chk("R1 idle rdata", rdata == 8'h00 ? 1 : 0, 1);
    @(negedge clk);
    chk("R1 rdata zero when idle", rdata, 8'h00);

    // R10: two instances on one wired-AND line
    chk("R10 line idle high", line, 1);
    peer_write(2'd2, 8'h02);
    chk("R10 peer drives", p_irq_n, 0);
    chk("R10 dut released", irq_n, 1);
    chk("R10 line low by peer", line, 0);
    dut_access(0, 2'd2, 8'h02);
    chk("R10 both drive", line, 0);
    peer_write(2'd0, 8'h00);
    chk("R10 peer released, dut holds", line, 0);
    dut_access(0, 2'd0, 8'h00);
    chk("R10 all released", line, 1);

    finished = 1;
    summary();
    $finish;
  end
endmodule